// File: doc/BRIEF.md
# SPI Command Frame Builder

This block turns one host command into the byte sequence that opens a transaction with an SPI peripheral. A command carries an 8-bit opcode, a 24-bit address, 32-bit write data, a 24-bit transfer size, a flag that marks a register in the peripheral's always-on domain, and a flag that turns the integrity trailer on or off. Once the block accepts a command, it sends the frame one byte at a time over a valid/ready stream toward the serial shifter.

The opcode selects which fields are packed into the frame and how long the frame is. When the trailer is enabled, a CRC7 byte ends the frame. The CRC is computed on the fly, one bit at a time, over each byte as that byte is accepted downstream. If the opcode is not supported, the block raises a one-cycle error and sends nothing. The block accepts a new command only while it is idle. It pulses a completion strobe once the last byte has been taken.

Top module: `spi_cmd_framer`

## Requirements
- R1: Seven opcodes are legal: 0xC3, 0xC4, 0xC7, 0xC8, 0xC9, 0xCA and 0xCF. Every frame sends the opcode as byte 0. An accepted command with any other opcode sets `opError` high for exactly the one cycle after acceptance, sends no bytes, and leaves the block idle.
- R2: For 0xC7, 0xC8, 0xC9 and 0xCA, bytes 1 to 3 are address bits [23:16], [15:8] and [7:0], in that order.
- R3: For 0xC3 and 0xC4, byte 1 is address bits [15:8] and byte 2 is address bits [7:0]. When `cmdClockless` is 1, bit 7 of byte 1 is forced to 1. For every other opcode, `cmdClockless` has no effect on the frame.
- R4: For 0xC4, byte 3 is 0x00. For 0xCF, bytes 1 to 3 are each 0xFF.
- R5: For 0xC7 and 0xC8, bytes 4 to 6 are size bits [23:16], [15:8] and [7:0]. Write data is sent most significant byte first, in bytes 4 to 7 for 0xC9 and in bytes 3 to 6 for 0xC3.
- R6: With the trailer enabled, the frame length is 5 bytes for 0xC4, 0xCA and 0xCF, 8 bytes for 0xC3, 0xC7 and 0xC8, and 9 bytes for 0xC9. With the trailer disabled, each frame is one byte shorter.
- R7: When the trailer is enabled, the last byte is {crc, 1'b0}. Here crc is the CRC7 with generator x^7+x^3+1 and initial value 0x7F, taken most significant bit first over every earlier byte of the frame.
- R8: `byteValid` rises in the cycle after a legal command is accepted. While `byteValid` is high and `byteReady` is low, `byteData` does not change.
- R9: `cmdReady` is high only while no frame is in progress. A `cmdValid` presented while a frame is in progress is ignored.
- R10: `frameDone` is high for exactly the one cycle after the last byte is accepted. In that cycle the block is already idle again.
- R11: After reset, `cmdReady` is 1 and `byteValid`, `frameDone` and `opError` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdOp | input | 8 | Opcode |
| cmdAddr | input | 24 | Target address |
| cmdData | input | 32 | Write data |
| cmdSize | input | 24 | Block transfer size in bytes |
| cmdClockless | input | 1 | Always-on register access flag |
| cmdCrcOn | input | 1 | Append the CRC7 trailer |
| byteValid | output | 1 | Frame byte present |
| byteReady | input | 1 | Downstream takes the byte |
| byteData | output | 8 | Frame byte |
| frameDone | output | 1 | Pulse after the last byte is taken |
| opError | output | 1 | Pulse after an unsupported opcode is accepted |

## Verification
A command is accepted on one rising edge. The result of that command shows up in the half-cycle after that edge. For a legal opcode, `byteValid` goes high with byte 0 on `byteData`. For an illegal opcode, `opError` goes high and stays high for only that cycle. Each later byte appears in the cycle after the previous byte was accepted. `frameDone` appears in the cycle after the final acceptance. The bench drives its inputs and samples the outputs on falling edges, counts cycles from the acceptance edge, and compares the bytes it receives against a frame it builds itself. It checks the trailer with a polynomial long division that it performs on its own. It sweeps every opcode with both trailer settings, both clockless settings and four backpressure patterns.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_BLK_WR  = 8'hC7;
  localparam logic [7:0] OP_BLK_RD  = 8'hC8;
  localparam logic [7:0] OP_WORD_WR = 8'hC9;
  localparam logic [7:0] OP_WORD_RD = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [6:0] CRC_INIT = 7'h7F;
  localparam logic [6:0] CRC_POLY = 7'h09;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a legal command
    logic advance;  // current byte taken downstream
    logic send;     // frame in progress
  } ctrlStrobe_t;

  // Fold one byte into a CRC7, most significant bit first
  function automatic logic [6:0] crc7Step(input logic [6:0] crcIn, input logic [7:0] dataIn);
    logic [6:0] c;
    logic fb;
    c = crcIn;
    for (int b = 7; b >= 0; b--) begin
      fb = c[6] ^ dataIn[b];
      c  = {c[5:0], 1'b0} ^ (fb ? CRC_POLY : 7'h00);
    end
    return c;
  endfunction

  function automatic logic opLegal(input logic [7:0] op);
    return (op == OP_INT_WR) || (op == OP_INT_RD) || (op == OP_BLK_WR) ||
           (op == OP_BLK_RD) || (op == OP_WORD_WR) || (op == OP_WORD_RD) ||
           (op == OP_RESET);
  endfunction

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        opOk,
  input  logic        byteReady,
  input  logic        lastByte,
  output logic        cmdReady,
  output logic        byteValid,
  output logic        frameDone,
  output logic        opError,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_SEND} ctrlState_t;

  ctrlState_t state, stateNext;
  logic accept;

  assign cmdReady  = (state == ST_IDLE);
  assign byteValid = (state == ST_SEND);
  assign accept    = cmdValid && cmdReady;

  always_comb begin
    strobe.load    = accept && opOk;
    strobe.send    = (state == ST_SEND);
    strobe.advance = (state == ST_SEND) && byteReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && opOk) stateNext = ST_SEND;
      ST_SEND: if (byteReady && lastByte) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
      opError   <= 1'b0;
    end else begin
      state     <= stateNext;
      frameDone <= (state == ST_SEND) && byteReady && lastByte;
      opError   <= accept && !opOk;
    end
  end

  // R10: completion strobe lasts one cycle and finds the block idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (cmdReady && !byteValid));
  // R1: error strobe lasts one cycle and never starts a frame
  p_err_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    opError |=> !opError);
  p_err_nosend_r1: assert property (@(posedge clk) disable iff (!rstN)
    opError |-> !byteValid);
  // R9: a command offered while busy cannot start anything
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !(byteReady && lastByte)) |=> (byteValid && !opError));

endmodule

// File: rtl/framer_datapath.sv
module framer_datapath
  import framer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic              cmdClockless,
  input  logic              cmdCrcOn,
  output logic              opOk,
  output logic              lastByte,
  output logic [7:0]        byteData
);

  localparam int AB        = ADDR_W / 8;
  localparam int DB        = DATA_W / 8;
  localparam int SB        = SIZE_W / 8;
  localparam int FRAME_MAX = 2 + AB + DB;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  logic [7:0]       frameNext [FRAME_MAX];
  logic [LEN_W-1:0] lenNext;
  logic [7:0]       frameQ    [FRAME_MAX];
  logic [LEN_W-1:0] frameLen;
  logic [LEN_W-1:0] idx;
  logic [6:0]       crcQ;
  logic             crcOnQ;
  logic             isTrailer;
  logic [7:0]       shortHi;

  assign opOk    = opLegal(cmdOp);
  assign shortHi = cmdAddr[15:8] | {cmdClockless, 7'b0};

  // Field packing per opcode (payload only, trailer appended later)
  always_comb begin
    for (int i = 0; i < FRAME_MAX; i++) frameNext[i] = 8'h00;
    frameNext[0] = cmdOp;
    lenNext      = LEN_W'(1 + AB);
    unique case (cmdOp)
      OP_WORD_WR: begin
        for (int i = 0; i < AB; i++) frameNext[1+i] = cmdAddr[8*(AB-1-i) +: 8];
        for (int i = 0; i < DB; i++) frameNext[1+AB+i] = cmdData[8*(DB-1-i) +: 8];
        lenNext = LEN_W'(1 + AB + DB);
      end
      OP_WORD_RD: begin
        for (int i = 0; i < AB; i++) frameNext[1+i] = cmdAddr[8*(AB-1-i) +: 8];
        lenNext = LEN_W'(1 + AB);
      end
      OP_BLK_WR, OP_BLK_RD: begin
        for (int i = 0; i < AB; i++) frameNext[1+i] = cmdAddr[8*(AB-1-i) +: 8];
        for (int i = 0; i < SB; i++) frameNext[1+AB+i] = cmdSize[8*(SB-1-i) +: 8];
        lenNext = LEN_W'(1 + AB + SB);
      end
      OP_INT_WR: begin
        frameNext[1] = shortHi;
        frameNext[2] = cmdAddr[7:0];
        for (int i = 0; i < DB; i++) frameNext[3+i] = cmdData[8*(DB-1-i) +: 8];
        lenNext = LEN_W'(3 + DB);
      end
      OP_INT_RD: begin
        frameNext[1] = shortHi;
        frameNext[2] = cmdAddr[7:0];
        frameNext[3] = 8'h00;
        lenNext = LEN_W'(4);
      end
      OP_RESET: begin
        frameNext[1] = 8'hFF;
        frameNext[2] = 8'hFF;
        frameNext[3] = 8'hFF;
        lenNext = LEN_W'(4);
      end
      default: lenNext = LEN_W'(1 + AB);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_MAX; i++) frameQ[i] <= 8'h00;
      frameLen <= '0;
      idx      <= '0;
      crcQ     <= CRC_INIT;
      crcOnQ   <= 1'b0;
    end else if (strobe.load) begin
      for (int i = 0; i < FRAME_MAX; i++) frameQ[i] <= frameNext[i];
      frameLen <= lenNext + LEN_W'(cmdCrcOn);
      idx      <= '0;
      crcQ     <= CRC_INIT;
      crcOnQ   <= cmdCrcOn;
    end else if (strobe.advance) begin
      idx <= idx + 1'b1;
      if (!isTrailer) crcQ <= crc7Step(crcQ, frameQ[idx]);
    end
  end

  assign lastByte  = (idx == frameLen - 1'b1);
  assign isTrailer = crcOnQ && lastByte;
  assign byteData  = isTrailer ? {crcQ, 1'b0} : frameQ[idx];

  // R8: a stalled byte holds its value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.send && !strobe.advance) |=> $stable(byteData));
  // R6: only the defined frame lengths are loaded
  p_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (frameLen == 4 || frameLen == 5 || frameLen == 7 ||
                     frameLen == 8 || frameLen == 9));
  // R6: the byte pointer never passes the frame end
  p_idx_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.send |-> (idx < frameLen));

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import framer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic              cmdClockless,
  input  logic              cmdCrcOn,
  output logic              byteValid,
  input  logic              byteReady,
  output logic [7:0]        byteData,
  output logic              frameDone,
  output logic              opError
);

  ctrlStrobe_t strobe;
  logic opOk;
  logic lastByte;

  framer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .opOk      (opOk),
    .byteReady (byteReady),
    .lastByte  (lastByte),
    .cmdReady  (cmdReady),
    .byteValid (byteValid),
    .frameDone (frameDone),
    .opError   (opError),
    .strobe    (strobe)
  );

  framer_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdOp        (cmdOp),
    .cmdAddr      (cmdAddr),
    .cmdData      (cmdData),
    .cmdSize      (cmdSize),
    .cmdClockless (cmdClockless),
    .cmdCrcOn     (cmdCrcOn),
    .opOk         (opOk),
    .lastByte     (lastByte),
    .byteData     (byteData)
  );

endmodule

// File: tb/sim_spi_cmd_framer.sv
module sim_spi_cmd_framer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [7:0]  cmdOp = 8'h00;
  logic [23:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic [23:0] cmdSize = '0;
  logic        cmdClockless = 1'b0;
  logic        cmdCrcOn = 1'b0;
  logic        byteValid;
  logic        byteReady = 1'b0;
  logic [7:0]  byteData;
  logic        frameDone;
  logic        opError;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_cmd_framer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdSize(cmdSize),
    .cmdClockless(cmdClockless), .cmdCrcOn(cmdCrcOn), .byteValid(byteValid),
    .byteReady(byteReady), .byteData(byteData), .frameDone(frameDone),
    .opError(opError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // CRC7 by long division of the bit string (init XORed into the first 7 bits)
  function automatic logic [6:0] refCrc(input logic [7:0] m [9], input int n);
    bit bv [80];
    logic [6:0] r;
    for (int k = 0; k < 80; k++) bv[k] = 1'b0;
    for (int k = 0; k < 8*n; k++) bv[k] = m[k/8][7-(k%8)];
    for (int k = 0; k < 7; k++) bv[k] = bv[k] ^ 1'b1;
    for (int i = 0; i < 8*n; i++)
      if (bv[i]) begin
        bv[i] = 1'b0; bv[i+4] = ~bv[i+4]; bv[i+7] = ~bv[i+7];
      end
    for (int k = 0; k < 7; k++) r[6-k] = bv[8*n+k];
    return r;
  endfunction

  function automatic string tagOf(input logic [7:0] op, input int pos, input int plen);
    if (pos == 0) return "R1";
    if (pos >= plen) return "R7";
    if (op == 8'hC3 || op == 8'hC4) begin
      if (pos <= 2) return "R3";
      if (op == 8'hC4) return "R4";
      return "R5";
    end
    if (op == 8'hCF) return "R4";
    if (pos <= 3) return "R2";
    return "R5";
  endfunction

  function automatic bit readyAt(input int pat, input int cyc);
    case (pat)
      0: return 1'b1;
      1: return (cyc % 2) == 1;
      2: return (cyc % 3) != 0;
      default: return cyc >= 3;
    endcase
  endfunction

  task automatic runFrame(input logic [7:0] op, input bit ck, input bit crcOn, input int pat);
    logic [23:0] a;
    logic [31:0] d;
    logic [23:0] s;
    logic [7:0]  exp [9];
    int plen, elen, got, cyc, lastCyc;
    bit legal, stall, rdy, sawDone;
    logic [7:0] prevData;
    logic [7:0] hi;

    a = {op, ~op, op ^ 8'h5A};
    d = {op + 8'd1, op * 8'd3, ~op, op ^ 8'hA5};
    s = {op ^ 8'h33, 8'h0F, op};
    for (int i = 0; i < 9; i++) exp[i] = 8'h00;
    exp[0] = op;
    legal = 1'b1;
    hi = a[15:8] | (ck ? 8'h80 : 8'h00);
    case (op)
      8'hC9: begin exp[1]=a[23:16]; exp[2]=a[15:8]; exp[3]=a[7:0];
                   exp[4]=d[31:24]; exp[5]=d[23:16]; exp[6]=d[15:8]; exp[7]=d[7:0]; plen=8; end
      8'hCA: begin exp[1]=a[23:16]; exp[2]=a[15:8]; exp[3]=a[7:0]; plen=4; end
      8'hC7, 8'hC8: begin exp[1]=a[23:16]; exp[2]=a[15:8]; exp[3]=a[7:0];
                   exp[4]=s[23:16]; exp[5]=s[15:8]; exp[6]=s[7:0]; plen=7; end
      8'hC3: begin exp[1]=hi; exp[2]=a[7:0];
                   exp[3]=d[31:24]; exp[4]=d[23:16]; exp[5]=d[15:8]; exp[6]=d[7:0]; plen=7; end
      8'hC4: begin exp[1]=hi; exp[2]=a[7:0]; exp[3]=8'h00; plen=4; end
      8'hCF: begin exp[1]=8'hFF; exp[2]=8'hFF; exp[3]=8'hFF; plen=4; end
      default: begin legal = 1'b0; plen = 0; end
    endcase
    elen = plen + (crcOn ? 1 : 0);
    if (legal && crcOn) exp[plen] = {refCrc(exp, plen), 1'b0};

    @(negedge clk);
    check(cmdReady == 1'b1, "R9 idle ready", cmdReady, 1);
    cmdOp = op; cmdAddr = a; cmdData = d; cmdSize = s;
    cmdClockless = ck; cmdCrcOn = crcOn; cmdValid = 1'b1; byteReady = 1'b0;
    @(negedge clk);
    // keep offering an illegal command while busy: it must be ignored
    cmdOp = 8'h00;

    if (!legal) begin
      check(opError == 1'b1, "R1 error pulse", opError, 1);
      check(byteValid == 1'b0, "R1 no bytes", byteValid, 0);
      cmdValid = 1'b0;
      @(negedge clk);
      check(opError == 1'b0, "R1 error one cycle", opError, 0);
      check(byteValid == 1'b0 && cmdReady == 1'b1, "R1 stays idle", byteValid, 0);
      return;
    end

    check(opError == 1'b0, "R1 legal no error", opError, 0);
    check(byteValid == 1'b1, "R8 first byte valid", byteValid, 1);
    got = 0; cyc = 0; lastCyc = -10; stall = 0; prevData = 8'h00; sawDone = 0;
    while (cyc < 80) begin
      if (frameDone) begin sawDone = 1; break; end
      if (opError || cmdReady) check(1'b0, "R9 busy ignores command", opError, 0);
      if (stall) check(byteData == prevData, "R8 hold", byteData, prevData);
      rdy = readyAt(pat, cyc);
      byteReady = rdy;
      if (byteValid && rdy) begin
        if (got >= elen) check(1'b0, "R6 extra byte", got, elen);
        else check(byteData == exp[got], tagOf(op, got, plen), byteData, exp[got]);
        got++;
        lastCyc = cyc;
      end
      stall = byteValid && !rdy;
      prevData = byteData;
      @(negedge clk);
      cyc++;
    end
    cmdValid = 1'b0;
    byteReady = 1'b0;
    check(got == elen, "R6 frame length", got, elen);
    check(sawDone && cyc == lastCyc + 1, "R10 done timing", cyc, lastCyc + 1);
    @(negedge clk);
    check(frameDone == 1'b0, "R10 done one cycle", frameDone, 0);
    check(cmdReady == 1'b1 && byteValid == 1'b0, "R10 idle after done", cmdReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(cmdReady == 1'b1, "R11 cmdReady", cmdReady, 1);
    check(byteValid == 1'b0, "R11 byteValid", byteValid, 0);
    check(frameDone == 1'b0, "R11 frameDone", frameDone, 0);
    check(opError == 1'b0, "R11 opError", opError, 0);
    rstN = 1'b1;
    for (int op = 0; op < 256; op++)
      for (int c = 0; c < 4; c++)
        runFrame(8'(op), c[0], c[1], (op + c) % 4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule